// File: doc/BRIEF.md
# Load-Store Ordering Predictor

This block lets loads run ahead of older stores whose addresses are not yet known, and it catches the cases where that turns out to be wrong. A load asks for permission to issue with its PC and sequence number and gets an allow or hold answer in the same cycle. Stores enter a small window at dispatch and are marked resolved when their address arrives. Each executed load is recorded with its address. When a store resolves to an address that a younger, already executed load used, the block reports that load's sequence number so that the pipeline can discard everything from that load onward and start again there.

Each violation also trains a direct-mapped pair table, indexed by a hash of the load PC, with the load PC and the PC of the store it collided with. Later, a load that hits that table is held only while an older store with the recorded store PC still has an unknown address. All other loads issue at once. The pipeline drives a flush (which removes everything at or after a sequence number) and a retire (which removes everything at or before one). The pair table keeps its contents through flushes and is cleared only by reset.

Top module: `mem_order_guard`

## Requirements
- R1: While reset is held and after it is released, `viol_valid_o` is low and every load request is allowed, because the pair table starts empty.
- R2: A load whose PC does not hit the pair table is allowed in the same cycle as its request, even when older stores in the window are unresolved.
- R3: When a store resolves to address A, every recorded load that is younger than that store and executed at address A is a violation. `viol_valid_o` goes high one cycle after the resolve, with `viol_seq_o` set to that load's sequence number. Loads that are older than the store, or that used another address, cause nothing.
- R4: A load that executes in the same cycle as a store resolve is compared against that resolve like a load that was already recorded.
- R5: When several loads violate against one resolve, only the oldest of them is reported.
- R6: Each violation writes the pair table entry at index `pc[5:2] ^ pc[9:6]` of the violating load's PC, storing the load PC as the tag and the store's PC. The write replaces whatever that entry held, and it takes effect for requests from the next cycle onward.
- R7: A load that hits the pair table (valid entry, tag equal to its PC) is held while the window has an unresolved store that is older than the load and carries the recorded store PC. It is allowed from the cycle after that store resolves. A store that is younger than the load never holds it.
- R8: A load whose PC maps to a trained index but differs from the stored tag is allowed.
- R9: A flush removes every store and load whose sequence number is at or younger than the flush number, including dispatches and executions in the flush cycle. A store resolve in a flush cycle updates a surviving store but reports no violation and trains nothing.
- R10: A retire removes every store and load whose sequence number is at or older than the retire number. A load held only by a retired store is then allowed.
- R11: A flush leaves the pair table unchanged, so a trained load is still held after it.
- R12: Sequence numbers are 6 bits wide, and they wrap. Entry a is older than entry b when bit 5 of (a - b) mod 64 is set, so a live window must span fewer than 32 numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_req_valid_i | input | 1 | Load issue request |
| ld_req_pc_i | input | 16 | PC of the requesting load |
| ld_req_seq_i | input | 6 | Sequence number of the requesting load |
| ld_req_allow_o | output | 1 | Low only when a valid request is held |
| st_disp_valid_i | input | 1 | Store enters the window |
| st_disp_seq_i | input | 6 | Sequence number of the dispatched store |
| st_disp_pc_i | input | 16 | PC of the dispatched store |
| st_res_valid_i | input | 1 | Store address becomes known |
| st_res_seq_i | input | 6 | Sequence number of the resolving store |
| st_res_addr_i | input | 16 | Resolved store address |
| ld_exec_valid_i | input | 1 | Load executes |
| ld_exec_seq_i | input | 6 | Sequence number of the executing load |
| ld_exec_pc_i | input | 16 | PC of the executing load |
| ld_exec_addr_i | input | 16 | Address read by the executing load |
| retire_valid_i | input | 1 | Retire up to and including a sequence number |
| retire_seq_i | input | 6 | Retire bound |
| flush_valid_i | input | 1 | Discard from a sequence number onward |
| flush_seq_i | input | 6 | First sequence number discarded |
| viol_valid_o | output | 1 | Ordering violation found |
| viol_seq_o | output | 6 | Sequence number of the violating load |

## Verification
Two functions can meet in one cycle: a load execute that arrives with the store resolve that it conflicts with, and a flush that arrives with a store resolve. The bench provokes both on purpose. In the first case the same-cycle load is older than a recorded conflicting load, so the report shows whether the same-cycle load took part in the oldest-load choice. In the second case a recorded conflicting load is still present during the flush, so any report or training is an error. A behavioural model, kept as queues, judges the allow answer and the violation outputs on every clock.

// File: rtl/mog_pkg.sv
`timescale 1ns/1ps
package mog_pkg;

  // a older than b when (a - b) mod 2^w has its top bit set
  function automatic logic older_than(input logic [31:0] a, input logic [31:0] b,
                                      input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

  function automatic logic [31:0] pt_hash(input logic [31:0] pc, input int unsigned iw);
    logic [31:0] m;
    m = (32'd1 << iw) - 32'd1;
    return ((pc >> 2) ^ (pc >> (2 + iw))) & m;
  endfunction

endpackage

// File: rtl/mog_pair_tbl.sv
`timescale 1ns/1ps
module mog_pair_tbl
  import mog_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned PC_W  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_hit_o,
  output logic [PC_W-1:0] lk_st_pc_o,
  input  logic            tr_v_i,
  input  logic [PC_W-1:0] tr_ld_pc_i,
  input  logic [PC_W-1:0] tr_st_pc_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] lk_idx, tr_idx;
  logic             vld   [DEPTH];
  logic [PC_W-1:0]  ld_pc [DEPTH];
  logic [PC_W-1:0]  st_pc [DEPTH];

  assign lk_idx = IDX_W'(pt_hash(32'(lk_pc_i), IDX_W));
  assign tr_idx = IDX_W'(pt_hash(32'(tr_ld_pc_i), IDX_W));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld[g]   <= 1'b0;
        ld_pc[g] <= '0;
        st_pc[g] <= '0;
      end else if (tr_v_i && tr_idx == IDX_W'(g)) begin
        vld[g]   <= 1'b1;
        ld_pc[g] <= tr_ld_pc_i;
        st_pc[g] <= tr_st_pc_i;
      end
    end
  end

  assign lk_hit_o   = vld[lk_idx] && (ld_pc[lk_idx] == lk_pc_i);
  assign lk_st_pc_o = st_pc[lk_idx];
endmodule

// File: rtl/mog_store_win.sv
`timescale 1ns/1ps
module mog_store_win
  import mog_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned SEQ_W = 6,
  parameter int unsigned PC_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_v_i,
  input  logic [SEQ_W-1:0] disp_seq_i,
  input  logic [PC_W-1:0]  disp_pc_i,
  input  logic             res_v_i,
  input  logic [SEQ_W-1:0] res_seq_i,
  input  logic             ret_v_i,
  input  logic [SEQ_W-1:0] ret_seq_i,
  input  logic             fl_v_i,
  input  logic [SEQ_W-1:0] fl_seq_i,
  input  logic             q_v_i,
  input  logic [PC_W-1:0]  q_pc_i,
  input  logic [SEQ_W-1:0] q_seq_i,
  output logic             q_pend_o,
  output logic             res_hit_o,
  output logic [PC_W-1:0]  res_pc_o,
  output logic [N-1:0]     occ_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic             vld   [N];
  logic             known [N];
  logic [SEQ_W-1:0] seq   [N];
  logic [PC_W-1:0]  pc    [N];
  logic             free_ok;
  logic [IW-1:0]    free_idx;
  logic             disp_ok;

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_ok  = 1'b1;
        free_idx = IW'(i);
      end
    end
    res_hit_o = 1'b0;
    res_pc_o  = '0;
    q_pend_o  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && !known[i] && seq[i] == res_seq_i) begin
        res_hit_o = res_v_i;
        res_pc_o  = pc[i];
      end
      if (vld[i] && !known[i] && pc[i] == q_pc_i &&
          older_than(32'(seq[i]), 32'(q_seq_i), SEQ_W))
        q_pend_o = q_v_i;
    end
  end

  assign disp_ok = disp_v_i && free_ok &&
                   !(fl_v_i && !older_than(32'(disp_seq_i), 32'(fl_seq_i), SEQ_W));

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic kill;
    assign kill = (fl_v_i && !older_than(32'(seq[g]), 32'(fl_seq_i), SEQ_W)) ||
                  (ret_v_i && !older_than(32'(ret_seq_i), 32'(seq[g]), SEQ_W));
    assign occ_o[g] = vld[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld[g]   <= 1'b0;
        known[g] <= 1'b0;
        seq[g]   <= '0;
        pc[g]    <= '0;
      end else if (vld[g]) begin
        if (kill) vld[g] <= 1'b0;
        else if (res_v_i && seq[g] == res_seq_i) known[g] <= 1'b1;
      end else if (disp_ok && free_idx == IW'(g)) begin
        vld[g]   <= 1'b1;
        known[g] <= 1'b0;
        seq[g]   <= disp_seq_i;
        pc[g]    <= disp_pc_i;
      end
    end
  end
endmodule

// File: rtl/mog_load_win.sv
`timescale 1ns/1ps
module mog_load_win
  import mog_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned SEQ_W  = 6,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ex_v_i,
  input  logic [SEQ_W-1:0]  ex_seq_i,
  input  logic [PC_W-1:0]   ex_pc_i,
  input  logic [ADDR_W-1:0] ex_addr_i,
  input  logic              ret_v_i,
  input  logic [SEQ_W-1:0]  ret_seq_i,
  input  logic              fl_v_i,
  input  logic [SEQ_W-1:0]  fl_seq_i,
  input  logic              chk_v_i,
  input  logic [SEQ_W-1:0]  chk_seq_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              hit_o,
  output logic [SEQ_W-1:0]  hit_seq_o,
  output logic [PC_W-1:0]   hit_pc_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic              vld  [N];
  logic [SEQ_W-1:0]  seq  [N];
  logic [PC_W-1:0]   pc   [N];
  logic [ADDR_W-1:0] addr [N];
  logic              free_ok;
  logic [IW-1:0]     free_idx;
  logic              ex_ok;

  // oldest younger load at the resolved address, same-cycle execute included
  always_comb begin
    hit_o     = 1'b0;
    hit_seq_o = '0;
    hit_pc_o  = '0;
    if (chk_v_i && ex_v_i && ex_addr_i == chk_addr_i &&
        older_than(32'(chk_seq_i), 32'(ex_seq_i), SEQ_W)) begin
      hit_o     = 1'b1;
      hit_seq_o = ex_seq_i;
      hit_pc_o  = ex_pc_i;
    end
    for (int i = 0; i < N; i++) begin
      if (chk_v_i && vld[i] && addr[i] == chk_addr_i &&
          older_than(32'(chk_seq_i), 32'(seq[i]), SEQ_W) &&
          (!hit_o || older_than(32'(seq[i]), 32'(hit_seq_o), SEQ_W))) begin
        hit_o     = 1'b1;
        hit_seq_o = seq[i];
        hit_pc_o  = pc[i];
      end
    end
  end

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_ok  = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign ex_ok = ex_v_i && free_ok &&
                 !(fl_v_i && !older_than(32'(ex_seq_i), 32'(fl_seq_i), SEQ_W));

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic kill;
    assign kill = (fl_v_i && !older_than(32'(seq[g]), 32'(fl_seq_i), SEQ_W)) ||
                  (ret_v_i && !older_than(32'(ret_seq_i), 32'(seq[g]), SEQ_W));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld[g]  <= 1'b0;
        seq[g]  <= '0;
        pc[g]   <= '0;
        addr[g] <= '0;
      end else if (vld[g]) begin
        if (kill) vld[g] <= 1'b0;
      end else if (ex_ok && free_idx == IW'(g)) begin
        vld[g]  <= 1'b1;
        seq[g]  <= ex_seq_i;
        pc[g]   <= ex_pc_i;
        addr[g] <= ex_addr_i;
      end
    end
  end
endmodule

// File: rtl/mem_order_guard.sv
`timescale 1ns/1ps
module mem_order_guard
  import mog_pkg::*;
#(
  parameter int unsigned SEQ_W    = 6,
  parameter int unsigned PC_W     = 16,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned N_ST     = 8,
  parameter int unsigned N_LD     = 8,
  parameter int unsigned PT_IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_req_valid_i,
  input  logic [PC_W-1:0]   ld_req_pc_i,
  input  logic [SEQ_W-1:0]  ld_req_seq_i,
  output logic              ld_req_allow_o,
  input  logic              st_disp_valid_i,
  input  logic [SEQ_W-1:0]  st_disp_seq_i,
  input  logic [PC_W-1:0]   st_disp_pc_i,
  input  logic              st_res_valid_i,
  input  logic [SEQ_W-1:0]  st_res_seq_i,
  input  logic [ADDR_W-1:0] st_res_addr_i,
  input  logic              ld_exec_valid_i,
  input  logic [SEQ_W-1:0]  ld_exec_seq_i,
  input  logic [PC_W-1:0]   ld_exec_pc_i,
  input  logic [ADDR_W-1:0] ld_exec_addr_i,
  input  logic              retire_valid_i,
  input  logic [SEQ_W-1:0]  retire_seq_i,
  input  logic              flush_valid_i,
  input  logic [SEQ_W-1:0]  flush_seq_i,
  output logic              viol_valid_o,
  output logic [SEQ_W-1:0]  viol_seq_o
);
  logic             pt_hit;
  logic [PC_W-1:0]  pt_st_pc;
  logic             st_pend;
  logic             res_hit;
  logic [PC_W-1:0]  res_pc;
  logic             chk_v;
  logic             det_hit;
  logic [SEQ_W-1:0] det_seq;
  logic [PC_W-1:0]  det_pc;
  logic [N_ST-1:0]  st_occ;

  assign chk_v = res_hit && !flush_valid_i;

  mog_pair_tbl #(.IDX_W(PT_IDX_W), .PC_W(PC_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_pc_i    (ld_req_pc_i),
    .lk_hit_o   (pt_hit),
    .lk_st_pc_o (pt_st_pc),
    .tr_v_i     (det_hit),
    .tr_ld_pc_i (det_pc),
    .tr_st_pc_i (res_pc)
  );

  mog_store_win #(.N(N_ST), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_st (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .disp_v_i   (st_disp_valid_i),
    .disp_seq_i (st_disp_seq_i),
    .disp_pc_i  (st_disp_pc_i),
    .res_v_i    (st_res_valid_i),
    .res_seq_i  (st_res_seq_i),
    .ret_v_i    (retire_valid_i),
    .ret_seq_i  (retire_seq_i),
    .fl_v_i     (flush_valid_i),
    .fl_seq_i   (flush_seq_i),
    .q_v_i      (pt_hit),
    .q_pc_i     (pt_st_pc),
    .q_seq_i    (ld_req_seq_i),
    .q_pend_o   (st_pend),
    .res_hit_o  (res_hit),
    .res_pc_o   (res_pc),
    .occ_o      (st_occ)
  );

  mog_load_win #(.N(N_LD), .SEQ_W(SEQ_W), .PC_W(PC_W), .ADDR_W(ADDR_W)) u_ld (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ex_v_i     (ld_exec_valid_i),
    .ex_seq_i   (ld_exec_seq_i),
    .ex_pc_i    (ld_exec_pc_i),
    .ex_addr_i  (ld_exec_addr_i),
    .ret_v_i    (retire_valid_i),
    .ret_seq_i  (retire_seq_i),
    .fl_v_i     (flush_valid_i),
    .fl_seq_i   (flush_seq_i),
    .chk_v_i    (chk_v),
    .chk_seq_i  (st_res_seq_i),
    .chk_addr_i (st_res_addr_i),
    .hit_o      (det_hit),
    .hit_seq_o  (det_seq),
    .hit_pc_o   (det_pc)
  );

  assign ld_req_allow_o = !(ld_req_valid_i && st_pend);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_valid_o <= 1'b0;
      viol_seq_o   <= '0;
    end else begin
      viol_valid_o <= det_hit;
      viol_seq_o   <= det_seq;
    end
  end
endmodule

// File: rtl/mog_checker.sv
`timescale 1ns/1ps
module mog_checker
  import mog_pkg::*;
#(
  parameter int unsigned SEQ_W = 6,
  parameter int unsigned N_ST  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             st_res_valid_i,
  input logic [SEQ_W-1:0] st_res_seq_i,
  input logic             flush_valid_i,
  input logic             ld_req_allow_o,
  input logic             viol_valid_o,
  input logic [SEQ_W-1:0] viol_seq_o,
  input logic [N_ST-1:0]  st_occ_i
);
  assert_viol_has_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_valid_o |-> $past(st_res_valid_i && !flush_valid_i));

  assert_viol_is_younger_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_valid_o |-> older_than(32'($past(st_res_seq_i)), 32'(viol_seq_o), SEQ_W));

  assert_flush_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_valid_i) |-> !viol_valid_o);

  assert_empty_window_allows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_occ_i == '0) |-> ld_req_allow_o);
endmodule

bind mem_order_guard mog_checker #(.SEQ_W(SEQ_W), .N_ST(N_ST)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .st_res_valid_i (st_res_valid_i),
  .st_res_seq_i   (st_res_seq_i),
  .flush_valid_i  (flush_valid_i),
  .ld_req_allow_o (ld_req_allow_o),
  .viol_valid_o   (viol_valid_o),
  .viol_seq_o     (viol_seq_o),
  .st_occ_i       (st_occ)
);

// File: tb/tb_mem_order_guard.sv
`timescale 1ns/1ps
module tb_mem_order_guard;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni;
  logic        ld_req_valid_i;
  logic [15:0] ld_req_pc_i;
  logic [5:0]  ld_req_seq_i;
  logic        ld_req_allow_o;
  logic        st_disp_valid_i;
  logic [5:0]  st_disp_seq_i;
  logic [15:0] st_disp_pc_i;
  logic        st_res_valid_i;
  logic [5:0]  st_res_seq_i;
  logic [15:0] st_res_addr_i;
  logic        ld_exec_valid_i;
  logic [5:0]  ld_exec_seq_i;
  logic [15:0] ld_exec_pc_i;
  logic [15:0] ld_exec_addr_i;
  logic        retire_valid_i;
  logic [5:0]  retire_seq_i;
  logic        flush_valid_i;
  logic [5:0]  flush_seq_i;
  logic        viol_valid_o;
  logic [5:0]  viol_seq_o;

  mem_order_guard dut (.*, .clk_i(clk));

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  typedef struct { int seq; int pc; bit known; } st_t;
  typedef struct { int seq; int pc; int addr; } ld_t;
  st_t sq[$];
  ld_t lq[$];
  bit  tv[16];
  int  tlp[16];
  int  tsp[16];
  bit  exp_v;
  int  exp_seq;

  function automatic bit older(int a, int b);
    return ((a - b) & 63) >= 32;
  endfunction

  function automatic int hidx(int pc);
    return ((pc >> 2) ^ (pc >> 6)) & 15;
  endfunction

  function automatic bit m_allow(int pc, int seq);
    int i = hidx(pc);
    if (!tv[i] || tlp[i] != pc) return 1'b1;
    foreach (sq[k])
      if (!sq[k].known && sq[k].pc == tsp[i] && older(sq[k].seq, seq)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic m_update();
    st_t ns[$];
    ld_t nl[$];
    bit  found = 1'b0;
    bit  nv = 1'b0;
    int  nseq = 0;
    int  npc = 0;
    int  spc = 0;
    int  rs = st_res_seq_i;
    int  ra = st_res_addr_i;
    if (!flush_valid_i && st_res_valid_i) begin
      foreach (sq[k]) if (sq[k].seq == rs && !sq[k].known) begin found = 1'b1; spc = sq[k].pc; end
      if (found) begin
        foreach (lq[k])
          if (older(rs, lq[k].seq) && lq[k].addr == ra && (!nv || older(lq[k].seq, nseq))) begin
            nv = 1'b1; nseq = lq[k].seq; npc = lq[k].pc;
          end
        if (ld_exec_valid_i && older(rs, ld_exec_seq_i) && ld_exec_addr_i == ra &&
            (!nv || older(ld_exec_seq_i, nseq))) begin
          nv = 1'b1; nseq = ld_exec_seq_i; npc = ld_exec_pc_i;
        end
        if (nv) begin
          tv[hidx(npc)] = 1'b1; tlp[hidx(npc)] = npc; tsp[hidx(npc)] = spc;
        end
      end
    end
    foreach (sq[k]) begin
      st_t s = sq[k];
      if (!((flush_valid_i && !older(s.seq, flush_seq_i)) ||
            (retire_valid_i && !older(retire_seq_i, s.seq)))) begin
        if (st_res_valid_i && s.seq == rs) s.known = 1'b1;
        ns.push_back(s);
      end
    end
    foreach (lq[k]) begin
      if (!((flush_valid_i && !older(lq[k].seq, flush_seq_i)) ||
            (retire_valid_i && !older(retire_seq_i, lq[k].seq))))
        nl.push_back(lq[k]);
    end
    if (st_disp_valid_i && !(flush_valid_i && !older(st_disp_seq_i, flush_seq_i)))
      ns.push_back('{int'(st_disp_seq_i), int'(st_disp_pc_i), 1'b0});
    if (ld_exec_valid_i && !(flush_valid_i && !older(ld_exec_seq_i, flush_seq_i)))
      nl.push_back('{int'(ld_exec_seq_i), int'(ld_exec_pc_i), int'(ld_exec_addr_i)});
    sq = ns;
    lq = nl;
    exp_v = nv;
    exp_seq = nseq;
  endtask

  task automatic clr();
    ld_req_valid_i = 0; ld_req_pc_i = 0; ld_req_seq_i = 0;
    st_disp_valid_i = 0; st_disp_seq_i = 0; st_disp_pc_i = 0;
    st_res_valid_i = 0; st_res_seq_i = 0; st_res_addr_i = 0;
    ld_exec_valid_i = 0; ld_exec_seq_i = 0; ld_exec_pc_i = 0; ld_exec_addr_i = 0;
    retire_valid_i = 0; retire_seq_i = 0; flush_valid_i = 0; flush_seq_i = 0;
  endtask

  // inputs are set after an edge; allow is judged before the next, viol after it
  task automatic cyc();
    #1;
    if (ld_req_valid_i) chk("ld_req_allow_o", ld_req_allow_o, m_allow(ld_req_pc_i, ld_req_seq_i));
    m_update();
    @(posedge clk);
    #1;
    chk("viol_valid_o", viol_valid_o, exp_v);
    if (exp_v) chk("viol_seq_o", viol_seq_o, exp_seq);
    clr();
  endtask

  task automatic req(int seq, int pc);
    ld_req_valid_i = 1; ld_req_seq_i = 6'(seq); ld_req_pc_i = 16'(pc);
  endtask
  task automatic disp(int seq, int pc);
    st_disp_valid_i = 1; st_disp_seq_i = 6'(seq); st_disp_pc_i = 16'(pc);
  endtask
  task automatic res(int seq, int addr);
    st_res_valid_i = 1; st_res_seq_i = 6'(seq); st_res_addr_i = 16'(addr);
  endtask
  task automatic exe(int seq, int pc, int addr);
    ld_exec_valid_i = 1; ld_exec_seq_i = 6'(seq); ld_exec_pc_i = 16'(pc); ld_exec_addr_i = 16'(addr);
  endtask
  task automatic fl(int seq);
    flush_valid_i = 1; flush_seq_i = 6'(seq);
  endtask
  task automatic ret(int seq);
    retire_valid_i = 1; retire_seq_i = 6'(seq);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #500us;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    clr();
    rst_ni = 0;
    repeat (3) @(posedge clk);
    // R1: reset state
    req(2, 'h40);
    #1;
    chk("viol_valid_o in reset", viol_valid_o, 0);
    chk("ld_req_allow_o in reset", ld_req_allow_o, 1);
    @(negedge clk);
    rst_ni = 1;
    @(posedge clk); #1;
    clr();
    req(2, 'h40); cyc();

    cur_req = "R2";
    disp(0, 'h104); cyc();
    disp(1, 'h100); cyc();
    req(2, 'h40); cyc();              // untrained load with older unresolved stores

    cur_req = "R3";
    exe(2, 'h40, 'h80); cyc();
    exe(3, 'h48, 'h90); cyc();
    res(0, 'h70); cyc();              // no matching address
    res(1, 'h80); cyc();              // load 2 violates, trains pair for 0x40
    cyc();

    cur_req = "R9";
    fl(2); cyc();
    cur_req = "R10";
    ret(1); cyc();

    cur_req = "R6";
    disp(4, 'h100); cyc();
    req(5, 'h40); cyc();              // trained: held
    cur_req = "R7";
    req(5, 'h40); cyc();
    req(5, 'h40); res(4, 'h300); cyc();  // resolve cycle still held
    req(5, 'h40); cyc();              // released
    disp(9, 'h100); cyc();
    req(8, 'h40); cyc();              // store younger than load

    cur_req = "R8";
    req(10, 'h04); exe(10, 'h04, 'h500); cyc();  // aliases index of 0x40
    res(9, 'h500); cyc();             // retrains index with tag 0x04
    disp(11, 'h100); cyc();
    req(13, 'h40); cyc();             // tag now differs
    cur_req = "R6";
    req(13, 'h04); cyc();
    cur_req = "R9";
    fl(10); cyc();
    ret(9); cyc();

    cur_req = "R4";
    disp(20, 'h100); cyc();
    exe(22, 'h40, 'hA0); cyc();
    cur_req = "R5";
    res(20, 'hA0); exe(21, 'h44, 'hA0); cyc();  // same-cycle load is oldest
    fl(21); cyc();
    ret(20); cyc();

    disp(30, 'h108); cyc();
    exe(33, 'h40, 'hB0); cyc();
    exe(31, 'h40, 'hB0); cyc();
    exe(32, 'h48, 'hB4); cyc();
    res(30, 'hB0); cyc();             // 31 and 33 conflict, 31 reported
    fl(31); cyc();
    ret(30); cyc();

    cur_req = "R11";
    disp(35, 'h108); cyc();
    req(36, 'h40); cyc();             // still trained after flushes
    cur_req = "R9";
    exe(37, 'h4C, 'hC0); cyc();
    fl(40); res(35, 'hC0); cyc();     // resolve in flush cycle: no report
    req(36, 'h40); cyc();
    fl(35); cyc();

    cur_req = "R10";
    disp(41, 'h108); cyc();
    req(42, 'h40); cyc();
    ret(41); cyc();
    req(42, 'h40); cyc();
    ret(42); cyc();

    cur_req = "R12";
    disp(62, 'h10C); cyc();
    exe(1, 'h50, 'hD0); cyc();
    exe(60, 'h54, 'hD0); cyc();
    res(62, 'hD0); cyc();             // load 1 is younger across the wrap
    disp(3, 'h10C); cyc();
    req(5, 'h50); cyc();
    req(2, 'h50); cyc();
    ret(5); cyc();
    cyc();

    report();
    $finish;
  end
endmodule